// File: doc/BRIEF.md
# I2C Transaction Sequencer with Packed Error Reporting

This block runs whole I2C transactions (register write, register read and device probe) on its own. It does so by driving the register port of a byte-level I2C bus engine, the way firmware would. A single command gives the 7-bit device address, 1 to 4 register-address bytes and a byte count. Write payload is taken from a valid/ready input stream, and read payload is handed out on a valid/ready output stream.

Every bus step is a write to the engine's data and control registers. The sequencer then polls the engine's interrupt flag at a fixed interval, reads the status code and compares it with the code that step must produce. The first mismatch, or a flag that never rises, ends the transaction. The sequencer then issues a STOP, which it does in every case, and reports a 32-bit word. The word is zero on success. On failure it carries an error class, the last control value read, the last status value read and the status code that was expected.

Top module: `i2c_txn_seq`

## Requirements
- R1: A command is taken only when `cmd_ready` is high (idle). `cmd_ready` stays low from the cycle after acceptance until `done` has pulsed. `cmd_op` selects the transaction: 0 = write, 1 = read, 2 or 3 = probe. `cmd_alen` holds the register-address byte count minus one.
- R2: A write issues START (expects 0x08), then sends chip address with bit 0 = 0 (expects 0x18), then the register-address bytes most significant first, then `cmd_len` payload bytes taken from the write stream. Each of these bytes expects 0x28. A count of zero sends no payload.
- R3: A read sends the write-address phase of R2 and then issues a repeated START with no STOP in between (expects 0x10). It then sends chip address with bit 0 = 1 (expects 0x40) and receives `cmd_len` bytes. Each byte is acknowledged except the last one, which gets a NAK. The expected codes are 0x50 after an ACK and 0x58 after a NAK.
- R4: A probe issues START and chip address with bit 0 = 1. It then receives one byte with a NAK and does not place that byte on the read stream.
- R5: When a status code differs from the expected one, the result is {0x01, last control, status read, expected}, from bit 31 down to bit 0. Every later step of that transaction is skipped.
- R6: If the interrupt flag (control bit 3) is still clear after `MAX_POLLS` waits of `POLL_CYC` cycles, the result is {0x02, last control, status read, expected}.
- R7: Every transaction ends with a STOP, failed ones included. The STOP is complete when the status reads 0xF8. If the status is still not 0xF8 after `MAX_POLLS` waits, an earlier error is kept. Otherwise the result becomes {0x02, control read, last status, 0xF8}.
- R8: Every control write sets the enable bit (bit 6). START uses bit 5, STOP uses bit 4 and ACK uses bit 2. The interrupt flag (bit 3) is always written as 0, which clears it. Engine register select: 0 = data, 1 = control, 2 = status.
- R9: A received byte stays on `rd_data` with `rd_valid` high until `rd_ready` is seen. A write payload byte is consumed (`wd_ready` high) only while `wd_valid` is high.
- R10: `done` is a one-cycle pulse. `result` is valid with it, and it is zero on success.
- R11: After reset the block is idle: `cmd_ready` = 1, and `done`, `rd_valid` and both engine strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Sequencer idle, command accepted |
| cmd_op | input | 2 | 0 write, 1 read, 2/3 probe |
| cmd_chip | input | 7 | Device address |
| cmd_alen | input | ALEN_W | Register-address bytes minus one |
| cmd_addr | input | 8*MAX_ABYTES | Register address, low bytes used |
| cmd_len | input | LEN_W | Payload byte count |
| wd_valid | input | 1 | Write payload byte present |
| wd_ready | output | 1 | Write payload byte taken |
| wd_data | input | 8 | Write payload byte |
| rd_valid | output | 1 | Received byte present |
| rd_ready | input | 1 | Received byte taken |
| rd_data | output | 8 | Received byte |
| done | output | 1 | Transaction finished (pulse) |
| result | output | 32 | Zero or packed error word |
| eng_wr | output | 1 | Engine register write strobe |
| eng_rd | output | 1 | Engine register read strobe |
| eng_sel | output | 2 | Engine register select |
| eng_wdata | output | 8 | Engine write data |
| eng_rdata | input | 8 | Engine read data, valid the cycle after `eng_rd` |

## Verification
The engine stub answers a control write after a fixed few cycles, and each read comes back one cycle after its strobe. The sequencer's result therefore appears only after several poll round trips and its STOP wait. For that reason, the bench waits for the `done` pulse rather than counting cycles, and it samples every output on the falling edge. A timeout is due no sooner than `MAX_POLLS*POLL_CYC` cycles after acceptance, and the bench checks the measured interval against that bound. Stream bytes are checked at the falling edge before the rising edge that consumes them. A stalled read byte is re-sampled on each falling edge of the stall to confirm it holds.

// File: rtl/i2c_seq_pkg.sv
// Shared codes and types for the I2C transaction sequencer.
// Assumes the engine's control and status layout described in the brief.
package i2c_seq_pkg;

    localparam int CB_ACK   = 2;
    localparam int CB_IFLG  = 3;
    localparam int CB_STOP  = 4;
    localparam int CB_START = 5;
    localparam int CB_EN    = 6;

    localparam logic [7:0] ST_START   = 8'h08;
    localparam logic [7:0] ST_RESTART = 8'h10;
    localparam logic [7:0] ST_AW_ACK  = 8'h18;
    localparam logic [7:0] ST_DW_ACK  = 8'h28;
    localparam logic [7:0] ST_AR_ACK  = 8'h40;
    localparam logic [7:0] ST_DR_ACK  = 8'h50;
    localparam logic [7:0] ST_DR_NAK  = 8'h58;
    localparam logic [7:0] ST_IDLE    = 8'hF8;

    localparam logic [7:0] EC_STATUS  = 8'h01;
    localparam logic [7:0] EC_TIMEOUT = 8'h02;

    localparam logic [1:0] SEL_DATA = 2'd0;
    localparam logic [1:0] SEL_CTRL = 2'd1;
    localparam logic [1:0] SEL_STAT = 2'd2;

    typedef enum logic [2:0] {
        PH_START, PH_ADDR_W, PH_REGADDR, PH_DATA,
        PH_RSTART, PH_ADDR_R, PH_RECV, PH_STOP
    } phase_e;

    typedef enum logic [1:0] {K_START, K_SEND, K_RECV, K_STOP} kind_e;

    // Build the diagnostic word from its four byte fields.
    function automatic logic [31:0] pack_err(input logic [7:0] cls,
                                             input logic [7:0] ctl,
                                             input logic [7:0] st,
                                             input logic [7:0] ex);
        return {cls, ctl, st, ex};
    endfunction

endpackage

// File: rtl/i2c_seq_poll.sv
// Poll pacing timer: counts one interval of POLL_CYC cycles per 'go'
// and how many intervals have elapsed since 'clr'.
// Assumes 'go' is only raised while the interval counter is idle.
module i2c_seq_poll #(
    parameter int POLL_CYC  = 1000,
    parameter int MAX_POLLS = 100,
    localparam int IVL_W = $clog2(POLL_CYC + 1),
    localparam int CNT_W = $clog2(MAX_POLLS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic go,
    output logic busy,
    output logic spent
);
    logic [IVL_W-1:0] ivl;
    logic [CNT_W-1:0] npoll;

    // Interval countdown and elapsed-interval count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ivl   <= '0;
            npoll <= '0;
        end else if (go) begin
            ivl   <= IVL_W'(POLL_CYC);
            npoll <= npoll + 1'b1;
        end else if (ivl != '0) begin
            ivl <= ivl - 1'b1;
        end
    end

    assign busy  = (ivl != '0);
    assign spent = (npoll == CNT_W'(MAX_POLLS));
endmodule

// File: rtl/i2c_seq_plan.sv
// Step planner: for the current phase gives the step kind, the byte to
// send, the expected status, the control value and the following phase.
// Assumes aleft >= 1 while in PH_REGADDR; pure combinational logic.
module i2c_seq_plan
    import i2c_seq_pkg::*;
#(
    parameter int MAX_ABYTES = 4,
    parameter int LEN_W      = 8,
    localparam int AIDX_W = $clog2(MAX_ABYTES + 1)
) (
    input  phase_e                    phase,
    input  logic                      op_rd,
    input  logic                      op_pr,
    input  logic [6:0]                chip,
    input  logic [8*MAX_ABYTES-1:0]   addr,
    input  logic [AIDX_W-1:0]         aleft,
    input  logic [LEN_W-1:0]          cnt,
    output kind_e                     kind,
    output logic [7:0]                tx_byte,
    output logic [7:0]                exp_st,
    output logic [7:0]                ctrl_val,
    output phase_e                    nxt
);
    logic [7:0] abyte;
    logic       ack;
    logic       more;

    // Pick the register-address byte that is due (most significant first).
    always_comb begin
        abyte = 8'h00;
        for (int i = 0; i < MAX_ABYTES; i++) begin
            if (aleft == AIDX_W'(i + 1)) abyte = addr[8*i +: 8];
        end
    end

    assign more = (cnt > LEN_W'(1));
    assign ack  = !op_pr && (cnt != LEN_W'(1));

    // Per-phase step description and successor phase.
    always_comb begin
        kind    = K_SEND;
        tx_byte = 8'h00;
        exp_st  = ST_DW_ACK;
        nxt     = PH_STOP;
        unique case (phase)
            PH_START: begin
                kind   = K_START;
                exp_st = ST_START;
                nxt    = op_pr ? PH_ADDR_R : PH_ADDR_W;
            end
            PH_ADDR_W: begin
                tx_byte = {chip, 1'b0};
                exp_st  = ST_AW_ACK;
                nxt     = PH_REGADDR;
            end
            PH_REGADDR: begin
                tx_byte = abyte;
                if (aleft > AIDX_W'(1)) nxt = PH_REGADDR;
                else if (op_rd)         nxt = PH_RSTART;
                else if (cnt != '0)     nxt = PH_DATA;
                else                    nxt = PH_STOP;
            end
            PH_DATA: begin
                nxt = more ? PH_DATA : PH_STOP;
            end
            PH_RSTART: begin
                kind   = K_START;
                exp_st = ST_RESTART;
                nxt    = PH_ADDR_R;
            end
            PH_ADDR_R: begin
                tx_byte = {chip, 1'b1};
                exp_st  = ST_AR_ACK;
                nxt     = (cnt != '0) ? PH_RECV : PH_STOP;
            end
            PH_RECV: begin
                kind   = K_RECV;
                exp_st = ack ? ST_DR_ACK : ST_DR_NAK;
                nxt    = more ? PH_RECV : PH_STOP;
            end
            default: begin
                kind   = K_STOP;
                exp_st = ST_IDLE;
            end
        endcase
    end

    // Control register image: enable always, flag written as zero.
    always_comb begin
        ctrl_val = 8'h00;
        ctrl_val[CB_EN]    = 1'b1;
        ctrl_val[CB_START] = (kind == K_START);
        ctrl_val[CB_STOP]  = (kind == K_STOP);
        ctrl_val[CB_ACK]   = (kind == K_RECV) && ack;
    end
endmodule

// File: rtl/i2c_txn_seq.sv
// I2C transaction sequencer: runs write, read and probe transactions by
// driving a byte-level bus engine's register port, polling its flag,
// checking each status code and ending every transaction with STOP.
// Assumes engine read data is valid the cycle after eng_rd.
module i2c_txn_seq
    import i2c_seq_pkg::*;
#(
    parameter int MAX_ABYTES = 4,
    parameter int LEN_W      = 8,
    parameter int POLL_CYC   = 1000,
    parameter int MAX_POLLS  = 100,
    localparam int ALEN_W = (MAX_ABYTES > 1) ? $clog2(MAX_ABYTES) : 1,
    localparam int AIDX_W = $clog2(MAX_ABYTES + 1),
    localparam int ADDR_W = 8 * MAX_ABYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_op,
    input  logic [6:0]        cmd_chip,
    input  logic [ALEN_W-1:0] cmd_alen,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic              wd_valid,
    output logic              wd_ready,
    input  logic [7:0]        wd_data,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [7:0]        rd_data,
    output logic              done,
    output logic [31:0]       result,
    output logic              eng_wr,
    output logic              eng_rd,
    output logic [1:0]        eng_sel,
    output logic [7:0]        eng_wdata,
    input  logic [7:0]        eng_rdata
);
    typedef enum logic [4:0] {
        S_IDLE, S_ISSUE, S_WDATA, S_WCTRL, S_PRD, S_PCHK, S_PWAIT,
        S_SRD, S_SCHK, S_DRD, S_DCHK, S_PUSH, S_ADV,
        S_STOPW, S_STRD, S_STCHK, S_STWAIT, S_SCRD, S_SCCHK, S_DONE
    } state_e;

    state_e             state;
    phase_e             phase;
    logic               op_rd, op_pr, to_q, rd_v;
    logic [6:0]         chip_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [AIDX_W-1:0]  aleft;
    logic [LEN_W-1:0]   cnt;
    logic [7:0]         last_ctrl, last_stat, rd_q;
    logic [31:0]        err_q;

    kind_e              kind;
    logic [7:0]         tx_byte, exp_st, ctrl_val;
    phase_e             nxt;
    logic               tm_clr, tm_go, tm_busy, tm_spent;

    i2c_seq_plan #(.MAX_ABYTES(MAX_ABYTES), .LEN_W(LEN_W)) i_plan (
        .phase(phase), .op_rd(op_rd), .op_pr(op_pr), .chip(chip_q),
        .addr(addr_q), .aleft(aleft), .cnt(cnt), .kind(kind),
        .tx_byte(tx_byte), .exp_st(exp_st), .ctrl_val(ctrl_val), .nxt(nxt)
    );

    i2c_seq_poll #(.POLL_CYC(POLL_CYC), .MAX_POLLS(MAX_POLLS)) i_poll (
        .clk(clk), .rst_n(rst_n), .clr(tm_clr), .go(tm_go),
        .busy(tm_busy), .spent(tm_spent)
    );

    // Engine port strobes, stream handshakes and timer controls per state.
    always_comb begin
        eng_wr    = 1'b0;
        eng_rd    = 1'b0;
        eng_sel   = SEL_CTRL;
        eng_wdata = ctrl_val;
        wd_ready  = 1'b0;
        tm_clr    = 1'b0;
        tm_go     = 1'b0;
        unique case (state)
            S_WDATA: begin
                eng_sel   = SEL_DATA;
                eng_wdata = (phase == PH_DATA) ? wd_data : tx_byte;
                eng_wr    = (phase != PH_DATA) || wd_valid;
                wd_ready  = (phase == PH_DATA) && wd_valid;
            end
            S_WCTRL, S_STOPW: begin
                eng_wr = 1'b1;
                tm_clr = 1'b1;
            end
            S_PRD, S_SCRD: eng_rd = 1'b1;
            S_SRD, S_STRD: begin
                eng_rd  = 1'b1;
                eng_sel = SEL_STAT;
            end
            S_DRD: begin
                eng_rd  = 1'b1;
                eng_sel = SEL_DATA;
            end
            S_PCHK:  tm_go = !eng_rdata[CB_IFLG] && !tm_spent;
            S_STCHK: tm_go = (eng_rdata != ST_IDLE) && !tm_spent;
            default: ;
        endcase
    end

    // Transaction state machine with first-error capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            phase     <= PH_START;
            op_rd     <= 1'b0;
            op_pr     <= 1'b0;
            to_q      <= 1'b0;
            rd_v      <= 1'b0;
            chip_q    <= '0;
            addr_q    <= '0;
            aleft     <= '0;
            cnt       <= '0;
            last_ctrl <= '0;
            last_stat <= '0;
            rd_q      <= '0;
            err_q     <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (cmd_valid) begin
                    op_pr  <= cmd_op[1];
                    op_rd  <= !cmd_op[1] && cmd_op[0];
                    chip_q <= cmd_chip;
                    addr_q <= cmd_addr;
                    aleft  <= AIDX_W'(cmd_alen) + 1'b1;
                    cnt    <= cmd_op[1] ? LEN_W'(1) : cmd_len;
                    err_q  <= '0;
                    phase  <= PH_START;
                    state  <= S_ISSUE;
                end
                S_ISSUE: begin
                    if (kind == K_STOP)      state <= S_STOPW;
                    else if (kind == K_SEND) state <= S_WDATA;
                    else                     state <= S_WCTRL;
                end
                S_WDATA: if (eng_wr) state <= S_WCTRL;
                S_WCTRL: state <= S_PRD;
                S_PRD:   state <= S_PCHK;
                S_PCHK: begin
                    last_ctrl <= eng_rdata;
                    if (eng_rdata[CB_IFLG]) begin
                        to_q  <= 1'b0;
                        state <= S_SRD;
                    end else if (tm_spent) begin
                        to_q  <= 1'b1;
                        state <= S_SRD;
                    end else begin
                        state <= S_PWAIT;
                    end
                end
                S_PWAIT: if (!tm_busy) state <= S_PRD;
                S_SRD:   state <= S_SCHK;
                S_SCHK: begin
                    last_stat <= eng_rdata;
                    if (to_q || eng_rdata != exp_st) begin
                        err_q <= pack_err(to_q ? EC_TIMEOUT : EC_STATUS,
                                          last_ctrl, eng_rdata, exp_st);
                        phase <= PH_STOP;
                        state <= S_STOPW;
                    end else if (kind == K_RECV) begin
                        state <= S_DRD;
                    end else begin
                        state <= S_ADV;
                    end
                end
                S_DRD: state <= S_DCHK;
                S_DCHK: begin
                    if (op_pr) begin
                        state <= S_ADV;
                    end else begin
                        rd_q  <= eng_rdata;
                        rd_v  <= 1'b1;
                        state <= S_PUSH;
                    end
                end
                S_PUSH: if (rd_ready) begin
                    rd_v  <= 1'b0;
                    state <= S_ADV;
                end
                S_ADV: begin
                    phase <= nxt;
                    if (phase == PH_REGADDR) aleft <= aleft - 1'b1;
                    if (phase == PH_DATA || phase == PH_RECV) cnt <= cnt - 1'b1;
                    state <= S_ISSUE;
                end
                S_STOPW: state <= S_STRD;
                S_STRD:  state <= S_STCHK;
                S_STCHK: begin
                    last_stat <= eng_rdata;
                    if (eng_rdata == ST_IDLE) state <= S_DONE;
                    else if (tm_spent)        state <= S_SCRD;
                    else                      state <= S_STWAIT;
                end
                S_STWAIT: if (!tm_busy) state <= S_STRD;
                S_SCRD:   state <= S_SCCHK;
                S_SCCHK: begin
                    if (err_q[31:24] == 8'h00)
                        err_q <= pack_err(EC_TIMEOUT, eng_rdata, last_stat, ST_IDLE);
                    state <= S_DONE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign cmd_ready = (state == S_IDLE);
    assign done      = (state == S_DONE);
    assign result    = err_q;
    assign rd_valid  = rd_v;
    assign rd_data   = rd_q;
endmodule

// File: rtl/i2c_seq_chk.sv
// Protocol checker for the transaction sequencer, bound to its ports.
module i2c_seq_chk
    import i2c_seq_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_valid,
    input logic        cmd_ready,
    input logic        wd_valid,
    input logic        wd_ready,
    input logic        rd_valid,
    input logic        rd_ready,
    input logic [7:0]  rd_data,
    input logic        done,
    input logic [31:0] result,
    input logic        eng_wr,
    input logic        eng_rd,
    input logic [1:0]  eng_sel,
    input logic [7:0]  eng_wdata
);
    // R1
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);
    // R1
    ready_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> cmd_ready);
    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R5
    result_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result == 32'h0 || result[31:24] == EC_STATUS
                  || result[31:24] == EC_TIMEOUT));
    // R8
    ctrl_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_wr && eng_sel == SEL_CTRL) |-> (eng_wdata[CB_EN] && !eng_wdata[CB_IFLG]));
    // R9
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
    // R9
    wd_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wd_ready |-> wd_valid);
    // R11
    port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(eng_wr && eng_rd));
endmodule

bind i2c_txn_seq i2c_seq_chk i_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .wd_valid(wd_valid), .wd_ready(wd_ready), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data), .done(done), .result(result),
    .eng_wr(eng_wr), .eng_rd(eng_rd), .eng_sel(eng_sel), .eng_wdata(eng_wdata)
);

// File: tb/test_i2c_txn_seq.sv
// Directed bench with a behavioural bus-engine stub.
module test_i2c_txn_seq;
    localparam int CLK_P = 10;
    localparam int PC    = 4;
    localparam int MP    = 5;
    localparam int DLY   = 3;
    localparam logic [6:0] DEV = 7'h50;

    logic clk = 0, rst_n = 0;
    logic cmd_valid = 0, cmd_ready;
    logic [1:0] cmd_op = 0;
    logic [6:0] cmd_chip = 0;
    logic [1:0] cmd_alen = 0;
    logic [31:0] cmd_addr = 0;
    logic [7:0] cmd_len = 0;
    logic wd_valid = 0, wd_ready;
    logic [7:0] wd_data = 0;
    logic rd_valid, rd_ready = 0;
    logic [7:0] rd_data;
    logic done;
    logic [31:0] result;
    logic eng_wr, eng_rd;
    logic [1:0] eng_sel;
    logic [7:0] eng_wdata;
    logic [7:0] eng_rdata;

    always #(CLK_P/2) clk = ~clk;

    i2c_txn_seq #(.MAX_ABYTES(4), .LEN_W(8), .POLL_CYC(PC), .MAX_POLLS(MP)) i_i2c_txn_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_chip(cmd_chip), .cmd_alen(cmd_alen),
        .cmd_addr(cmd_addr), .cmd_len(cmd_len), .wd_valid(wd_valid),
        .wd_ready(wd_ready), .wd_data(wd_data), .rd_valid(rd_valid),
        .rd_ready(rd_ready), .rd_data(rd_data), .done(done), .result(result),
        .eng_wr(eng_wr), .eng_rd(eng_rd), .eng_sel(eng_sel),
        .eng_wdata(eng_wdata), .eng_rdata(eng_rdata)
    );

    // ---------------- engine stub ----------------
    logic hang = 0, stop_hang = 0;
    logic [7:0] s_ctrl, s_stat, s_data;
    logic in_txn, first_b, rx_mode, p_ack;
    int   p_cnt;
    logic [1:0] p_kind;          // 0 start 1 stop 2 send 3 recv
    int   rx_n;
    byte  ev [0:255];
    byte  sent [0:255];
    int   n_ev, n_sent, n_noen, n_rdv;

    always @(posedge clk) begin
        if (!rst_n) begin
            s_ctrl <= 8'h00; s_stat <= 8'hF8; s_data <= 8'h00;
            in_txn <= 0; first_b <= 0; rx_mode <= 0; p_cnt <= 0;
            p_kind <= 0; p_ack <= 0; rx_n <= 0; eng_rdata <= 8'h00;
            n_ev <= 0; n_sent <= 0; n_noen <= 0;
        end else begin
            if (eng_rd)
                eng_rdata <= (eng_sel == 2'd0) ? s_data :
                             (eng_sel == 2'd1) ? s_ctrl : s_stat;
            if (eng_wr && eng_sel == 2'd0) s_data <= eng_wdata;
            if (eng_wr && eng_sel == 2'd1) begin
                s_ctrl <= eng_wdata;
                if (!eng_wdata[6]) n_noen <= n_noen + 1;
                p_cnt <= DLY;
                p_ack <= eng_wdata[2];
                if (eng_wdata[5]) begin p_kind <= 0; ev[n_ev] <= "S"; end
                else if (eng_wdata[4]) begin p_kind <= 1; ev[n_ev] <= "P"; end
                else if (rx_mode) begin
                    p_kind <= 3; ev[n_ev] <= eng_wdata[2] ? "A" : "N";
                end else begin
                    p_kind <= 2; ev[n_ev] <= "B";
                    sent[n_sent] <= s_data; n_sent <= n_sent + 1;
                end
                n_ev <= n_ev + 1;
            end else if (p_cnt != 0) begin
                p_cnt <= p_cnt - 1;
                if (p_cnt == 1) begin
                    case (p_kind)
                        2'd0: if (!hang) begin
                            s_stat <= in_txn ? 8'h10 : 8'h08;
                            in_txn <= 1; first_b <= 1; rx_mode <= 0;
                            s_ctrl[3] <= 1'b1;
                        end
                        2'd1: begin
                            if (!stop_hang) s_stat <= 8'hF8;
                            in_txn <= 0; rx_mode <= 0;
                        end
                        2'd2: if (!hang) begin
                            if (first_b) begin
                                if (s_data[7:1] == DEV) begin
                                    s_stat <= s_data[0] ? 8'h40 : 8'h18;
                                    rx_mode <= s_data[0];
                                end else s_stat <= s_data[0] ? 8'h48 : 8'h20;
                            end else s_stat <= 8'h28;
                            first_b <= 0;
                            s_ctrl[3] <= 1'b1;
                        end
                        default: if (!hang) begin
                            s_data <= 8'hA0 + 8'(rx_n);
                            rx_n <= rx_n + 1;
                            s_stat <= p_ack ? 8'h50 : 8'h58;
                            s_ctrl[3] <= 1'b1;
                        end
                    endcase
                end
            end
        end
    end

    always @(negedge clk) if (!rst_n) n_rdv <= 0; else if (rd_valid) n_rdv <= n_rdv + 1;

    // ---------------- checking helpers ----------------
    int n_chk = 0, n_fail = 0;
    logic [31:0] res_q;
    int cyc = 0, t_acc, t_done;
    byte wbuf [0:15];
    byte rbuf [0:15];
    int  hold_bad;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_ev(input int base, input string exp, input string req);
        bit ok = (n_ev - base) == exp.len();
        for (int i = 0; i < exp.len() && ok; i++) if (ev[base+i] != exp[i]) ok = 0;
        check(ok, req, 32'(n_ev - base), 32'(exp.len()));
    endtask

    task automatic check_sent(input int base, input byte exp[], input string req);
        bit ok = (n_sent - base) == exp.size();
        for (int i = 0; i < exp.size() && ok; i++) if (sent[base+i] != exp[i]) ok = 0;
        check(ok, req, {24'h0, sent[base]}, {24'h0, exp[0]});
    endtask

    task automatic run_cmd(input logic [1:0] op, input logic [6:0] chip,
                           input logic [1:0] alen, input logic [31:0] addr,
                           input logic [7:0] len, input int nwd, input int nrd,
                           input int stall);
        @(negedge clk);
        cmd_op = op; cmd_chip = chip; cmd_alen = alen; cmd_addr = addr;
        cmd_len = len; cmd_valid = 1;
        @(posedge clk); #1 cmd_valid = 0;
        t_acc = cyc;
        @(negedge clk);
        check(!cmd_ready, "R1 busy after accept", 32'(cmd_ready), 0);
        hold_bad = 0;
        fork
            begin
                for (int i = 0; i < nwd; i++) begin
                    wd_data = wbuf[i]; wd_valid = 1;
                    do @(negedge clk); while (!wd_ready);
                    @(posedge clk); #1;
                end
                wd_valid = 0;
            end
            begin
                for (int i = 0; i < nrd; i++) begin
                    byte d0;
                    do @(negedge clk); while (!rd_valid);
                    d0 = rd_data;
                    for (int k = 0; k < stall; k++) begin
                        @(negedge clk);
                        if (!rd_valid || rd_data != d0) hold_bad++;
                    end
                    rd_ready = 1;
                    @(posedge clk); #1 rd_ready = 0;
                    rbuf[i] = d0;
                end
            end
            begin
                do @(negedge clk); while (!done);
                res_q = result; t_done = cyc;
                @(negedge clk);
                check(!done && cmd_ready, "R10 done pulse", 32'(done), 0);
            end
        join
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset;
        check(cmd_ready && !done && !rd_valid && !eng_wr && !eng_rd,
              "R11 reset idle", {cmd_ready, done, rd_valid, eng_wr, eng_rd}, 5'b10000);
    endtask

    task automatic t_write;
        int be = n_ev, bs = n_sent;
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
        run_cmd(2'd0, DEV, 2'd1, 32'h1234, 8'd3, 3, 0, 0);
        check(res_q == 0, "R2 write result", res_q, 0);
        check_ev(be, "SBBBBBBP", "R2 write step order");
        check_sent(bs, '{8'hA0, 8'h12, 8'h34, 8'h11, 8'h22, 8'h33}, "R2 write bytes");
        check(n_noen == 0, "R8 enable on every control write", 32'(n_noen), 0);
    endtask

    task automatic t_read;
        int be = n_ev, bs = n_sent, r0 = rx_n;
        bit ok = 1;
        run_cmd(2'd1, DEV, 2'd0, 32'h07, 8'd3, 0, 3, 3);
        check(res_q == 0, "R3 read result", res_q, 0);
        check_ev(be, "SBBSBAANP", "R3 repeated start, ack/nak order");
        check_sent(bs, '{8'hA0, 8'h07, 8'hA1}, "R3 read bytes sent");
        for (int i = 0; i < 3; i++) if (rbuf[i] != byte'(8'hA0 + r0 + i)) ok = 0;
        check(ok, "R3 read data", {24'h0, rbuf[0]}, 32'(8'hA0 + r0));
        check(hold_bad == 0, "R9 read byte held under stall", 32'(hold_bad), 0);
    endtask

    task automatic t_read4;
        int be = n_ev, bs = n_sent;
        run_cmd(2'd1, DEV, 2'd3, 32'hDEADBEEF, 8'd1, 0, 1, 0);
        check(res_q == 0, "R3 4-byte address read result", res_q, 0);
        check_ev(be, "SBBBBBSBNP", "R3 4-byte address order");
        check_sent(bs, '{8'hA0, 8'hDE, 8'hAD, 8'hBE, 8'hEF, 8'hA1}, "R2 address msb first");
    endtask

    task automatic t_probe;
        int be = n_ev, rv = n_rdv;
        run_cmd(2'd2, DEV, 2'd0, 0, 8'd0, 0, 0, 0);
        check(res_q == 0, "R4 probe present", res_q, 0);
        check_ev(be, "SBNP", "R4 probe order");
        check(n_rdv == rv, "R4 dummy byte not streamed", 32'(n_rdv - rv), 0);
        be = n_ev;
        run_cmd(2'd2, 7'h33, 2'd0, 0, 8'd0, 0, 0, 0);
        check(res_q == 32'h01484840, "R5 probe absent word", res_q, 32'h01484840);
        check_ev(be, "SBP", "R7 stop after probe failure");
    endtask

    task automatic t_absent_write;
        int be = n_ev;
        run_cmd(2'd0, 7'h33, 2'd0, 32'h01, 8'd2, 0, 0, 0);
        check(res_q == 32'h01482018, "R5 write nak word", res_q, 32'h01482018);
        check_ev(be, "SBP", "R5 later steps skipped, R7 stop");
    endtask

    task automatic t_zero_len;
        int be = n_ev;
        run_cmd(2'd0, DEV, 2'd0, 32'h5A, 8'd0, 0, 0, 0);
        check(res_q == 0, "R2 zero payload result", res_q, 0);
        check_ev(be, "SBBP", "R2 zero payload order");
    endtask

    task automatic t_timeout;
        int be = n_ev;
        hang = 1;
        run_cmd(2'd0, DEV, 2'd0, 32'h01, 8'd0, 0, 0, 0);
        hang = 0;
        check(res_q == 32'h0260F808, "R6 start timeout word", res_q, 32'h0260F808);
        check(t_done - t_acc >= MP * PC, "R6 timeout not early", 32'(t_done - t_acc), MP * PC);
        check_ev(be, "SP", "R7 stop after timeout");
    endtask

    task automatic t_stop_hang;
        wbuf[0] = 8'h44;
        stop_hang = 1;
        run_cmd(2'd0, DEV, 2'd0, 32'h02, 8'd1, 1, 0, 0);
        check(res_q == 32'h025028F8, "R7 stop timeout word", res_q, 32'h025028F8);
        run_cmd(2'd0, 7'h33, 2'd0, 32'h02, 8'd0, 0, 0, 0);
        check(res_q == 32'h01482018, "R7 first error kept", res_q, 32'h01482018);
        stop_hang = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        t_reset();
        t_write();
        t_read();
        t_read4();
        t_probe();
        t_absent_write();
        t_zero_len();
        t_timeout();
        t_stop_hang();
        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule